// File: doc/BRIEF.md
# BCD Time-of-Day Register Bank with Indirect Byte Port

This block keeps calendar time in eight byte-wide registers: a control byte plus second, minute, hour, weekday with a century flag, day of month, month and two-digit year. Every time field is held in packed BCD. An internal prescaler divides the system clock down to a one-second step. Each step carries through the fields in BCD, taking account of month lengths and of February in leap years. A halt flag in the seconds byte freezes the count. The time is set by ordinary byte writes. Each write is masked to the bits its field uses and checked against the field's legal range. A write that fails the check leaves the field as it was.

Software reaches the bank through a four-offset byte port. Two offsets load the low and high bytes of a 16-bit location pointer. A third offset reads or writes the byte at that location. The location can be a cell of an internal byte memory, one of the eight time registers (at `RTC_BASE` to `RTC_BASE+7`), or a reserved slot seven below `RTC_BASE`. A data write returns the pointer to zero. Read data appears one cycle after the read strobe and is qualified by `bus_rvalid`.

Top module: `rtc_bcd_regfile`

## Requirements
- R1: After reset the registers read: control 0x90, seconds 0x00 with halt clear, minutes 0x00, hours 0x00, weekday/century 0x01, date 0x01, month 0x01, year 0x00.
- R2: While halt is clear, seconds advance by one in BCD every `CLKS_PER_SEC` cycles. Second 59 wraps to 00 and carries into minutes. Minute 59 wraps and carries into hours.
- R3: Hour 23 wraps to 00 and advances the weekday (7 goes to 1) and the date. The date wraps to 01 after 30 in April, June, September and November, after 31 in the other months, and after 28 in February, or after 29 when the year's value is divisible by 4. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R4: Bit 7 of the seconds byte (offset +1) is the halt flag. While it is set, no field changes. Once it is cleared, counting continues from the frozen value.
- R5: A seconds or minutes write takes the low 7 bits as BCD and accepts only 00 to 59. The halt flag takes bit 7 of every seconds write, whether or not the value was accepted. A seconds read returns the halt flag in bit 7 above the BCD seconds.
- R6: Writes to the remaining time fields are checked as follows, and a value that fails leaves the field unchanged. Hours use the low 6 bits and accept 00 to 23. Date uses the low 6 bits and accepts 01 to 31. Month uses the low 5 bits and accepts 01 to 12. Year uses all 8 bits and accepts 00 to 99 with both digits legal.
- R7: The weekday byte (offset +4) stores the weekday in bits 2:0 and a century flag in bit 6. Reads return exactly those two fields, with all other bits zero.
- R8: A control write (offset +0) stores the written byte with bit 5 cleared and bits 7 and 4 set.
- R9: A time-field write takes effect at the next clock edge and restarts the prescaler. The next automatic step comes exactly `CLKS_PER_SEC` cycles after that edge.
- R10: Port offset 0 loads pointer bits 7:0 and offset 1 loads bits 15:8. An offset-3 write stores to the addressed location and then clears the pointer to zero. An offset-3 read returns the addressed byte on the cycle after the strobe and leaves the pointer unchanged.
- R11: Reads at port offsets 0, 1 and 2 return 0xFF. A write at offset 2 has no effect.
- R12: Locations below `MEM_BYTES` are read/write memory. Any other location that is neither a time register nor the reserved slot reads 0xFF, and writes to it are discarded without aliasing into memory.
- R13: The reserved slot at `RTC_BASE-7` always reads 0x00, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe at `bus_off` |
| bus_rd | input | 1 | Byte read strobe at `bus_off` |
| bus_off | input | 2 | Port offset: 0 pointer low, 1 pointer high, 3 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | High for one cycle, one cycle after `bus_rd` |

## Verification
The hardest states to reach from the port are the calendar carries: end of a 30-day month, February 28 in a common year and a leap year, February 29, and the 99-to-00 year wrap. All of them need time to pass. The bench sets the halt flag, loads the date and 23:59, then releases the clock with a seconds write of 59. After one prescaler period it halts the clock again with a seconds write, so the rolled-over state stays frozen while the fields are read back. The exact cycle of each step is checked with back-to-back data reads after a seconds write. This also shows that clearing halt with an out-of-range value resumes from the frozen second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Register slots relative to RTC_BASE; the order is decoded by the port.
  typedef enum logic [2:0] {
    SLOT_CTRL = 3'd0,
    SLOT_SEC  = 3'd1,
    SLOT_MIN  = 3'd2,
    SLOT_HOUR = 3'd3,
    SLOT_DOW  = 3'd4,
    SLOT_DATE = 3'd5,
    SLOT_MON  = 3'd6,
    SLOT_YEAR = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    SRC_ONES = 2'd0,
    SRC_ZERO = 2'd1,
    SRC_MEM  = 2'd2,
    SRC_TOD  = 2'd3
  } rsrc_e;

  typedef struct packed {
    logic [7:0] ctrl;
    logic       halt;
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic       cent;
    logic [2:0] dow;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] year;
  } tod_t;

  localparam tod_t TOD_RESET = '{ctrl: 8'h90, halt: 1'b0, sec: 8'h00, min: 8'h00,
                                 hour: 8'h00, cent: 1'b0, dow: 3'd1, date: 8'h01,
                                 mon: 8'h01, year: 8'h00};

  // Legal packed-BCD byte within [lo, hi]; legal BCD orders like binary.
  function automatic logic bcd_in_range(input logic [7:0] v, input logic [7:0] lo,
                                        input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year value mod 4 from BCD: tens*10 contributes tens*2.
  function automatic logic bcd_leap(input logic [7:0] yr);
    logic [1:0] m4;
    m4 = {yr[4], 1'b0} + yr[1:0];
    return m4 == 2'd0;
  endfunction

  function automatic logic [7:0] days_in_month(input logic [7:0] mon, input logic [7:0] yr);
    if (mon == 8'h02) return bcd_leap(yr) ? 8'h29 : 8'h28;
    else if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) return 8'h30;
    else return 8'h31;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned CLKS_PER_SEC = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic halt,
  output logic tick
);
  localparam int unsigned CW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST) && !halt;

  always_ff @(posedge clk) begin
    if (rst || restart || halt) cnt_q <= '0;
    else if (tick)              cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  generate
    if (CLKS_PER_SEC > 1) begin : g_multi
      // R9
      restart_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  slot_e      wr_slot,
  input  logic [7:0] wr_data,
  output logic       wr_time,
  output tod_t       tod
);
  tod_t tod_q;
  tod_t adv;
  logic sec_wrap, min_wrap, hour_wrap, date_wrap, mon_wrap, day_roll;

  assign wr_time = wr_en && (wr_slot != SLOT_CTRL);
  assign tod     = tod_q;

  // One-second carry chain in BCD.
  always_comb begin
    sec_wrap  = tod_q.sec  == 8'h59;
    min_wrap  = tod_q.min  == 8'h59;
    hour_wrap = tod_q.hour == 8'h23;
    date_wrap = tod_q.date >= days_in_month(tod_q.mon, tod_q.year);
    mon_wrap  = tod_q.mon  == 8'h12;
    day_roll  = sec_wrap && min_wrap && hour_wrap;
    adv       = tod_q;
    adv.sec   = sec_wrap ? 8'h00 : bcd_inc(tod_q.sec);
    if (sec_wrap)             adv.min  = min_wrap ? 8'h00 : bcd_inc(tod_q.min);
    if (sec_wrap && min_wrap) adv.hour = hour_wrap ? 8'h00 : bcd_inc(tod_q.hour);
    if (day_roll) begin
      adv.dow  = (tod_q.dow >= 3'd7) ? 3'd1 : tod_q.dow + 3'd1;
      adv.date = date_wrap ? 8'h01 : bcd_inc(tod_q.date);
    end
    if (day_roll && date_wrap) adv.mon = mon_wrap ? 8'h01 : bcd_inc(tod_q.mon);
    if (day_roll && date_wrap && mon_wrap)
      adv.year = (tod_q.year == 8'h99) ? 8'h00 : bcd_inc(tod_q.year);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_q <= TOD_RESET;
    end else begin
      if (tick && !wr_time) tod_q <= adv;
      if (wr_en) begin
        case (wr_slot)
          SLOT_CTRL: tod_q.ctrl <= (wr_data & 8'h5F) | 8'h90;
          SLOT_SEC: begin
            tod_q.halt <= wr_data[7];
            if (bcd_in_range({1'b0, wr_data[6:0]}, 8'h00, 8'h59))
              tod_q.sec <= {1'b0, wr_data[6:0]};
          end
          SLOT_MIN:
            if (bcd_in_range({1'b0, wr_data[6:0]}, 8'h00, 8'h59))
              tod_q.min <= {1'b0, wr_data[6:0]};
          SLOT_HOUR:
            if (bcd_in_range({2'b0, wr_data[5:0]}, 8'h00, 8'h23))
              tod_q.hour <= {2'b0, wr_data[5:0]};
          SLOT_DOW: begin
            tod_q.dow  <= wr_data[2:0];
            tod_q.cent <= wr_data[6];
          end
          SLOT_DATE:
            if (bcd_in_range({2'b0, wr_data[5:0]}, 8'h01, 8'h31))
              tod_q.date <= {2'b0, wr_data[5:0]};
          SLOT_MON:
            if (bcd_in_range({3'b0, wr_data[4:0]}, 8'h01, 8'h12))
              tod_q.mon <= {3'b0, wr_data[4:0]};
          SLOT_YEAR:
            if (bcd_in_range(wr_data, 8'h00, 8'h99)) tod_q.year <= wr_data;
        endcase
      end
    end
  end

  // R4
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (tod_q.halt && !wr_en) |=> ($stable(tod_q.sec) && $stable(tod_q.date)));
  // R2
  sec_bcd_chk: assert property (@(posedge clk) disable iff (rst)
    (tod_q.sec[3:0] <= 4'd9) && (tod_q.sec[7:4] <= 4'd5));
  // R3
  date_range_chk: assert property (@(posedge clk) disable iff (rst)
    (tod_q.date >= 8'h01) && (tod_q.date <= 8'h31));
  // R6
  mon_range_chk: assert property (@(posedge clk) disable iff (rst)
    (tod_q.mon >= 8'h01) && (tod_q.mon <= 8'h12));
  // R5
  min_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_slot == SLOT_MIN && wr_data[6:0] > 7'h59) |=> $stable(tod_q.min));
  // R8
  ctrl_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    tod_q.ctrl[7] && tod_q.ctrl[4] && !tod_q.ctrl[5]);

endmodule

// File: rtl/rtc_bcd_regfile.sv
module rtc_bcd_regfile
  import rtc_pkg::*;
#(
  parameter int unsigned MEM_BYTES    = 1024,
  parameter logic [15:0] RTC_BASE     = 16'h1FF8,
  parameter int unsigned CLKS_PER_SEC = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_off,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_rvalid
);
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned MEM_AW  = $clog2(MEM_BYTES);
  localparam logic [ADDR_W-1:0] MEM_END   = ADDR_W'(MEM_BYTES);
  localparam logic [ADDR_W-1:0] RTC_LAST  = RTC_BASE + 16'd7;
  localparam logic [ADDR_W-1:0] RSVD_ADDR = RTC_BASE - 16'd7;

  logic [ADDR_W-1:0] addr_q;
  logic              in_mem, in_tod, is_rsvd, data_wr;
  logic [2:0]        slot_idx;
  slot_e             slot;
  logic              wr_time, tick;
  tod_t              tod;
  logic [7:0]        ram_q, tod_byte, tod_byte_q;
  rsrc_e             src, rsrc_q;

  assign in_mem   = addr_q < MEM_END;
  assign in_tod   = (addr_q >= RTC_BASE) && (addr_q <= RTC_LAST);
  assign is_rsvd  = addr_q == RSVD_ADDR;
  assign data_wr  = bus_wr && (bus_off == 2'd3);
  assign slot_idx = addr_q[2:0] - RTC_BASE[2:0];
  assign slot     = slot_e'(slot_idx);

  // Location pointer: two byte loads, cleared after each data write.
  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (bus_wr) begin
      case (bus_off)
        2'd0:    addr_q[7:0]  <= bus_wdata;
        2'd1:    addr_q[15:8] <= bus_wdata;
        2'd3:    addr_q       <= '0;
        default: addr_q       <= addr_q;
      endcase
    end
  end

  rtc_byte_ram #(.DEPTH(MEM_BYTES), .AW(MEM_AW)) u_ram (
    .clk   (clk),
    .we    (data_wr && in_mem),
    .addr  (addr_q[MEM_AW-1:0]),
    .wdata (bus_wdata),
    .rdata (ram_q)
  );

  rtc_prescaler #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .restart (wr_time),
    .halt    (tod.halt),
    .tick    (tick)
  );

  rtc_time_core u_core (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_en   (data_wr && in_tod),
    .wr_slot (slot),
    .wr_data (bus_wdata),
    .wr_time (wr_time),
    .tod     (tod)
  );

  always_comb begin
    case (slot)
      SLOT_CTRL: tod_byte = tod.ctrl;
      SLOT_SEC:  tod_byte = tod.sec | {tod.halt, 7'b0};
      SLOT_MIN:  tod_byte = tod.min;
      SLOT_HOUR: tod_byte = tod.hour;
      SLOT_DOW:  tod_byte = {1'b0, tod.cent, 3'b000, tod.dow};
      SLOT_DATE: tod_byte = tod.date;
      SLOT_MON:  tod_byte = tod.mon;
      SLOT_YEAR: tod_byte = tod.year;
    endcase
  end

  always_comb begin
    if (bus_off != 2'd3) src = SRC_ONES;
    else if (in_mem)     src = SRC_MEM;
    else if (in_tod)     src = SRC_TOD;
    else if (is_rsvd)    src = SRC_ZERO;
    else                 src = SRC_ONES;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      rsrc_q     <= SRC_ONES;
      tod_byte_q <= 8'h00;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        rsrc_q     <= src;
        tod_byte_q <= tod_byte;
      end
    end
  end

  always_comb begin
    case (rsrc_q)
      SRC_ZERO: bus_rdata = 8'h00;
      SRC_MEM:  bus_rdata = ram_q;
      SRC_TOD:  bus_rdata = tod_byte_q;
      default:  bus_rdata = 8'hFF;
    endcase
  end

  // R10
  addr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (addr_q == '0));
  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  // R11
  ones_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_off != 2'd3) |=> (bus_rdata == 8'hFF));
  // R13
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_off == 2'd3 && is_rsvd) |=> (bus_rdata == 8'h00));

endmodule

// File: tb/tb_rtc_bcd_regfile.sv
module tb_rtc_bcd_regfile;
  localparam int          N    = 8;
  localparam logic [15:0] RB   = 16'h1FF8;
  localparam logic [15:0] A_CTRL = RB,          A_SEC  = RB + 16'd1, A_MIN = RB + 16'd2;
  localparam logic [15:0] A_HOUR = RB + 16'd3,  A_DOW  = RB + 16'd4, A_DATE = RB + 16'd5;
  localparam logic [15:0] A_MON  = RB + 16'd6,  A_YEAR = RB + 16'd7, A_RSVD = RB - 16'd7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_off = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;

  int   compared = 0;
  int   mismatched = 0;
  logic done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  rtc_bcd_regfile #(.MEM_BYTES(1024), .RTC_BASE(RB), .CLKS_PER_SEC(N)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  // Monitor: compares each returned byte against the scoreboard head.
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R10: unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (bus_rdata !== e) begin
          mismatched++;
          $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] o, input logic [7:0] d);
    bus_off = o; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] o, input logic [7:0] e, input string t);
    bus_off = o; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr(2'd0, a[7:0]);
    wr(2'd1, a[15:8]);
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    set_addr(a);
    wr(2'd3, d);
  endtask

  task automatic peek(input logic [15:0] a, input logic [7:0] e, input string t);
    set_addr(a);
    rd_expect(2'd3, e, t);
  endtask

  // Load a date at 23:59:59, run one second, freeze, read back.
  task automatic rollover_case(input logic [7:0] y, input logic [7:0] m, input logic [7:0] d,
                               input logic [7:0] ey, input logic [7:0] em,
                               input logic [7:0] ed, input string t);
    poke(A_SEC, 8'h80);
    poke(A_YEAR, y);
    poke(A_MON, m);
    poke(A_DATE, d);
    poke(A_HOUR, 8'h23);
    poke(A_MIN, 8'h59);
    poke(A_SEC, 8'h59);
    repeat (N + 2) @(negedge clk);
    poke(A_SEC, 8'h80);
    peek(A_DATE, ed, t);
    peek(A_MON, em, t);
    peek(A_YEAR, ey, t);
    peek(A_HOUR, 8'h00, t);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset values (seconds first, before the first step)
    peek(A_SEC,  8'h00, "R1 seconds");
    peek(A_CTRL, 8'h90, "R1 control");
    peek(A_MIN,  8'h00, "R1 minutes");
    peek(A_HOUR, 8'h00, "R1 hours");
    peek(A_DOW,  8'h01, "R1 weekday");
    peek(A_DATE, 8'h01, "R1 date");
    peek(A_MON,  8'h01, "R1 month");
    peek(A_YEAR, 8'h00, "R1 year");

    // R2 R3 R9: full carry from 23:59:58 on Feb 28, 2023, weekday 7
    poke(A_SEC, 8'h80);
    poke(A_YEAR, 8'h23);
    poke(A_MON, 8'h02);
    poke(A_DATE, 8'h28);
    poke(A_HOUR, 8'h23);
    poke(A_MIN, 8'h59);
    poke(A_DOW, 8'h07);
    poke(A_SEC, 8'h58);
    set_addr(A_SEC);
    for (int k = 3; k <= 20; k++) begin
      logic [7:0] e;
      e = (k <= N) ? 8'h58 : (k <= 2 * N) ? 8'h59 : 8'h00;
      rd_expect(2'd3, e, "R9 R2 second step timing");
    end
    peek(A_MIN,  8'h00, "R2 minute carry");
    peek(A_HOUR, 8'h00, "R3 hour wrap");
    peek(A_DATE, 8'h01, "R3 Feb 28 common year");
    peek(A_MON,  8'h03, "R3 month carry");
    peek(A_YEAR, 8'h23, "R3 year kept");
    peek(A_DOW,  8'h01, "R3 weekday 7 to 1");

    rollover_case(8'h24, 8'h02, 8'h28, 8'h24, 8'h02, 8'h29, "R3 leap Feb 28");
    rollover_case(8'h24, 8'h02, 8'h29, 8'h24, 8'h03, 8'h01, "R3 leap Feb 29");
    rollover_case(8'h23, 8'h04, 8'h30, 8'h23, 8'h05, 8'h01, "R3 April 30");
    rollover_case(8'h23, 8'h01, 8'h31, 8'h23, 8'h02, 8'h01, "R3 Jan 31");
    rollover_case(8'h99, 8'h12, 8'h31, 8'h00, 8'h01, 8'h01, "R3 year 99 wrap");

    // R4 halt freezes, clearing with an invalid value resumes from frozen second
    poke(A_SEC, 8'hB7);
    repeat (3 * N) @(negedge clk);
    peek(A_SEC, 8'hB7, "R4 frozen");
    poke(A_SEC, 8'h7F);
    set_addr(A_SEC);
    for (int k = 3; k <= N + 3; k++) begin
      logic [7:0] e;
      e = (k <= N) ? 8'h37 : 8'h38;
      rd_expect(2'd3, e, "R4 resume from frozen");
    end
    poke(A_SEC, 8'h80);
    peek(A_SEC, 8'h80, "R5 halt with zero");
    poke(A_SEC, 8'hE5);
    peek(A_SEC, 8'h80, "R5 invalid seconds, halt latched");

    // R5 minutes
    poke(A_MIN, 8'h21); peek(A_MIN, 8'h21, "R5 min valid");
    poke(A_MIN, 8'h60); peek(A_MIN, 8'h21, "R5 min 60 dropped");
    poke(A_MIN, 8'h5A); peek(A_MIN, 8'h21, "R5 min bad digit dropped");
    poke(A_MIN, 8'hC5); peek(A_MIN, 8'h45, "R5 min bit7 masked");

    // R6 other fields
    poke(A_HOUR, 8'h11); peek(A_HOUR, 8'h11, "R6 hour valid");
    poke(A_HOUR, 8'h24); peek(A_HOUR, 8'h11, "R6 hour 24 dropped");
    poke(A_HOUR, 8'h1A); peek(A_HOUR, 8'h11, "R6 hour bad digit dropped");
    poke(A_HOUR, 8'h52); peek(A_HOUR, 8'h12, "R6 hour masked");
    poke(A_DATE, 8'h15); peek(A_DATE, 8'h15, "R6 date valid");
    poke(A_DATE, 8'h00); peek(A_DATE, 8'h15, "R6 date zero dropped");
    poke(A_DATE, 8'h32); peek(A_DATE, 8'h15, "R6 date 32 dropped");
    poke(A_DATE, 8'hC7); peek(A_DATE, 8'h07, "R6 date masked");
    poke(A_DATE, 8'h31); peek(A_DATE, 8'h31, "R6 date 31 accepted");
    poke(A_MON, 8'h05);  peek(A_MON, 8'h05, "R6 month valid");
    poke(A_MON, 8'h13);  peek(A_MON, 8'h05, "R6 month 13 dropped");
    poke(A_MON, 8'h00);  peek(A_MON, 8'h05, "R6 month zero dropped");
    poke(A_MON, 8'hE9);  peek(A_MON, 8'h09, "R6 month masked");
    poke(A_MON, 8'h12);  peek(A_MON, 8'h12, "R6 month 12 accepted");
    poke(A_YEAR, 8'h42); peek(A_YEAR, 8'h42, "R6 year valid");
    poke(A_YEAR, 8'hA0); peek(A_YEAR, 8'h42, "R6 year A0 dropped");
    poke(A_YEAR, 8'h4F); peek(A_YEAR, 8'h42, "R6 year bad digit dropped");
    poke(A_YEAR, 8'h99); peek(A_YEAR, 8'h99, "R6 year 99 accepted");

    // R7 weekday and century
    poke(A_DOW, 8'hFF); peek(A_DOW, 8'h47, "R7 all ones");
    poke(A_DOW, 8'h03); peek(A_DOW, 8'h03, "R7 plain weekday");

    // R8 control
    poke(A_CTRL, 8'h00); peek(A_CTRL, 8'h90, "R8 zero");
    poke(A_CTRL, 8'hFF); peek(A_CTRL, 8'hDF, "R8 ones");
    poke(A_CTRL, 8'h2C); peek(A_CTRL, 8'h9C, "R8 mixed");

    // R10 R12 memory and pointer
    poke(16'h0000, 8'h3C);
    poke(16'h0005, 8'hA5);
    rd_expect(2'd3, 8'h3C, "R10 pointer cleared after write");
    set_addr(16'h0005);
    rd_expect(2'd3, 8'hA5, "R10 read data");
    rd_expect(2'd3, 8'hA5, "R10 read keeps pointer");
    poke(16'h03FF, 8'h5E); peek(16'h03FF, 8'h5E, "R12 last memory byte");
    poke(16'h0400, 8'h77); peek(16'h0400, 8'hFF, "R12 above memory reads ones");
    peek(16'h0000, 8'h3C, "R12 no alias into memory");
    peek(16'h1000, 8'hFF, "R12 unmapped reads ones");

    // R11 other offsets
    rd_expect(2'd0, 8'hFF, "R11 offset 0 read");
    rd_expect(2'd1, 8'hFF, "R11 offset 1 read");
    rd_expect(2'd2, 8'hFF, "R11 offset 2 read");
    set_addr(16'h0005);
    wr(2'd2, 8'h00);
    rd_expect(2'd3, 8'hA5, "R11 offset 2 write ignored");

    // R13 reserved slot
    peek(A_RSVD, 8'h00, "R13 reserved reads zero");
    poke(A_RSVD, 8'h55);
    peek(A_RSVD, 8'h00, "R13 reserved write dropped");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R10: missing read data actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule